// File: doc/BRIEF.md
# Frame Pulse Format Detector and Sampler

This block sits behind the frame-pulse input of a time-slot switch. It works out on its own which of two framing conventions is in use and supplies the bit and channel timing that matches it. The master clock runs at two clocks per serial bit. A frame is 32 channels of 8 bits, so a frame lasts 512 master clocks. A frame pulse is one master clock wide and is recognised by its level against the idle level around it. A low pulse on a high idle line selects the falling-edge-boundary convention. A high pulse on a low idle line selects the rising-edge-boundary convention, which this block reports as `format_is_gci`.

The block locks once it sees two pulses of the same kind exactly one frame apart. From each recognised pulse it keeps a frame position counter. That counter drives a bit-boundary strobe, a sample strobe on the second clock of each two-clock bit cell (the three-quarter point), and channel and bit counts. Downstream shifters use `format_is_gci` to pick the clock edge for those strobes. The block does no data shifting itself.

Top module: `frame_format_detector`

## Requirements
- R1: While `rst` is high, after a clock edge the outputs read `format_valid`=0, `format_is_gci`=0, `channel_count`=0, `bit_count`=0, `bit_boundary`=1 and `sample_enable`=0.
- R2: A frame pulse is one clock of one level with the other level on the clocks on each side. A low pulse gives `format_is_gci`=0 and a high pulse gives `format_is_gci`=1. A level held for two or more clocks is not a pulse and has no effect on timing.
- R3: Edge P is the clock edge that samples a pulse. If a pulse of the same level is sampled exactly 512 edges after the previous one, `format_valid` rises after edge P+2.
- R4: While locked, if no pulse is sampled at the expected edge, `format_valid` is low after edge P+2 counted from that expected edge.
- R5: While locked, a pulse sampled at any other spacing clears `format_valid` after its edge P+2. That pulse becomes the new reference, and a pulse 512 edges later locks again.
- R6: After the idle level flips to the other convention, `format_valid` returns once two pulses of the new level, 512 edges apart, have been sampled. `format_is_gci` then shows the new convention.
- R7: Let m (0 to 511) be the number of edges after edge P of the most recent pulse. Then `bit_count` = (m/2) mod 8 and `channel_count` = m/16, counting from 0.
- R8: `bit_boundary` is high when m is even and `sample_enable` is high when m is odd, so each two-clock bit cell has one boundary and then one sample strobe.
- R9: While `format_valid` stays high, `format_is_gci` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, two periods per serial bit |
| rst | input | 1 | Synchronous active-high reset |
| frame_pulse | input | 1 | Frame pulse of either polarity |
| format_valid | output | 1 | Lock indication: framing confirmed over two frames |
| format_is_gci | output | 1 | 1 when the pulse is active high (rising-edge boundary convention) |
| bit_boundary | output | 1 | Strobe on the first clock of each bit cell |
| sample_enable | output | 1 | Strobe on the second clock of each bit cell |
| channel_count | output | 5 | Channel index within the frame, 0 to 31 |
| bit_count | output | 3 | Bit index within the channel, 0 to 7 |

## Verification
A frame position counter that slips shows up at once as wrong channel and bit counts and swapped strobes on the next sampled clock. The bench compares every clock of every pulsed frame against the offset from the last pulse. A lock state machine that misjudges spacing or pulse shape shows up as a wrong `format_valid` exactly two edges after the pulse edge that should decide it. That point is checked in every frame, covering the missing, displaced, widened and reversed-polarity pulse cases.

// File: rtl/ffd_pkg.sv
package ffd_pkg;

    // Two master clocks make one serial bit cell.
    localparam int CLKS_PER_BIT = 2;

    typedef enum logic [1:0] {
        TRK_SEARCH    = 2'd0,
        TRK_CANDIDATE = 2'd1,
        TRK_LOCKED    = 2'd2
    } trk_state_e;

    // One isolated single-clock level seen on the pulse line.
    typedef struct packed {
        logic hit;
        logic high_level;
    } pulse_evt_t;

    // Strobes within one bit cell.
    typedef struct packed {
        logic boundary;
        logic sample;
    } bit_phase_t;

    function automatic int frame_clocks(input int channels, input int bits);
        return channels * bits * CLKS_PER_BIT;
    endfunction

endpackage

// File: rtl/ffd_pulse_classifier.sv
module ffd_pulse_classifier
    import ffd_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       fp_in,
    output pulse_evt_t evt
);

    // hist[0] newest sample, hist[2] oldest. Kept free-running so that it
    // always mirrors the pin history.
    logic [2:0] hist;

    always_ff @(posedge clk) begin
        hist <= {hist[1:0], fp_in};
    end

    always_comb begin
        evt.hit        = (hist[1] != hist[0]) && (hist[1] != hist[2]);
        evt.high_level = hist[1];
    end

    // R2: an event reports the level the pin held one clock earlier, with
    // the opposite level one clock before that.
    assert_event_matches_pin_R2: assert property (@(posedge clk) disable iff (rst)
        evt.hit |-> (evt.high_level == $past(fp_in, 2)) && (evt.high_level != $past(fp_in, 3)));

endmodule

// File: rtl/ffd_frame_tracker.sv
module ffd_frame_tracker
    import ffd_pkg::*;
#(
    parameter int FRAME_CLKS = 512,
    parameter int POS_W      = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  pulse_evt_t       evt,
    output logic [POS_W-1:0] pos,
    output logic             locked,
    output logic             high_pol
);

    // The event is seen one edge after the pulse edge (position 0), so the
    // expected slot is position 1 and a reload lands on position 2.
    localparam logic [POS_W-1:0] SLOT_POS   = POS_W'(1);
    localparam logic [POS_W-1:0] RELOAD_POS = POS_W'(2);
    localparam logic [POS_W-1:0] LAST_POS   = POS_W'(FRAME_CLKS - 1);

    trk_state_e state;
    logic       at_slot;

    assign at_slot = (pos == SLOT_POS);
    assign locked  = (state == TRK_LOCKED);

    always_ff @(posedge clk) begin
        if (rst) begin
            pos      <= '0;
            state    <= TRK_SEARCH;
            high_pol <= 1'b0;
        end else if (evt.hit) begin
            pos      <= RELOAD_POS;
            high_pol <= evt.high_level;
            if (state == TRK_SEARCH) begin
                state <= TRK_CANDIDATE;
            end else if (at_slot && (evt.high_level == high_pol)) begin
                state <= TRK_LOCKED;
            end else begin
                state <= TRK_CANDIDATE;
            end
        end else begin
            pos <= (pos == LAST_POS) ? '0 : pos + POS_W'(1);
            if (at_slot && (state != TRK_SEARCH)) begin
                state <= TRK_SEARCH;
            end
        end
    end

    assert_lock_on_slot_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(locked) |-> ($past(pos) == SLOT_POS) && (pos == RELOAD_POS));

    assert_missing_drops_R4: assert property (@(posedge clk) disable iff (rst)
        (locked && at_slot && !evt.hit) |=> !locked);

    assert_offslot_drops_R5: assert property (@(posedge clk) disable iff (rst)
        (evt.hit && !at_slot) |=> !locked);

    assert_polarity_steady_R9: assert property (@(posedge clk) disable iff (rst)
        (locked && $past(locked)) |-> $stable(high_pol));

endmodule

// File: rtl/ffd_bit_timing.sv
module ffd_bit_timing
    import ffd_pkg::*;
#(
    parameter int N_CHANNELS = 32,
    parameter int N_BITS     = 8,
    parameter int POS_W      = 9,
    parameter int CH_W       = 5,
    parameter int BIT_W      = 3
) (
    input  logic [POS_W-1:0] pos,
    output logic [CH_W-1:0]  channel,
    output logic [BIT_W-1:0] bit_idx,
    output bit_phase_t       phase
);

    localparam int CLKS_PER_CH = N_BITS * CLKS_PER_BIT;

    int unsigned pos_u;
    int unsigned cell_phase;

    always_comb begin
        pos_u          = 32'(pos);
        cell_phase     = pos_u % CLKS_PER_BIT;
        phase.boundary = (cell_phase == 0);
        phase.sample   = (cell_phase == CLKS_PER_BIT - 1);
        bit_idx        = BIT_W'((pos_u / CLKS_PER_BIT) % N_BITS);
        channel        = CH_W'((pos_u / CLKS_PER_CH) % N_CHANNELS);
    end

endmodule

// File: rtl/frame_format_detector.sv
module frame_format_detector
    import ffd_pkg::*;
#(
    parameter int N_CHANNELS = 32,
    parameter int N_BITS     = 8,
    localparam int FRAME_CLKS = frame_clocks(N_CHANNELS, N_BITS),
    localparam int POS_W      = $clog2(FRAME_CLKS),
    localparam int CH_W       = $clog2(N_CHANNELS),
    localparam int BIT_W      = $clog2(N_BITS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             frame_pulse,
    output logic             format_valid,
    output logic             format_is_gci,
    output logic             bit_boundary,
    output logic             sample_enable,
    output logic [CH_W-1:0]  channel_count,
    output logic [BIT_W-1:0] bit_count
);

    pulse_evt_t       evt;
    logic [POS_W-1:0] frame_pos;
    bit_phase_t       phase;

    ffd_pulse_classifier u_classifier (
        .clk   (clk),
        .rst   (rst),
        .fp_in (frame_pulse),
        .evt   (evt)
    );

    ffd_frame_tracker #(
        .FRAME_CLKS (FRAME_CLKS),
        .POS_W      (POS_W)
    ) u_tracker (
        .clk      (clk),
        .rst      (rst),
        .evt      (evt),
        .pos      (frame_pos),
        .locked   (format_valid),
        .high_pol (format_is_gci)
    );

    ffd_bit_timing #(
        .N_CHANNELS (N_CHANNELS),
        .N_BITS     (N_BITS),
        .POS_W      (POS_W),
        .CH_W       (CH_W),
        .BIT_W      (BIT_W)
    ) u_timing (
        .pos     (frame_pos),
        .channel (channel_count),
        .bit_idx (bit_count),
        .phase   (phase)
    );

    assign bit_boundary  = phase.boundary;
    assign sample_enable = phase.sample;

    assert_boundary_then_sample_R8: assert property (@(posedge clk) disable iff (rst)
        (bit_boundary && !evt.hit) |=> sample_enable);

    assert_bit_advance_R7: assert property (@(posedge clk) disable iff (rst)
        (sample_enable && !evt.hit && (bit_count != BIT_W'(N_BITS - 1)))
            |=> (bit_count == $past(bit_count) + BIT_W'(1)) && $stable(channel_count));

endmodule

// File: tb/frame_format_detector_tb.sv
module frame_format_detector_tb;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst;
    logic       frame_pulse;
    logic       format_valid;
    logic       format_is_gci;
    logic       bit_boundary;
    logic       sample_enable;
    logic [4:0] channel_count;
    logic [2:0] bit_count;

    int n_tests = 0;
    int n_fail  = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    frame_format_detector u_dut (
        .clk           (clk),
        .rst           (rst),
        .frame_pulse   (frame_pulse),
        .format_valid  (format_valid),
        .format_is_gci (format_is_gci),
        .bit_boundary  (bit_boundary),
        .sample_enable (sample_enable),
        .channel_count (channel_count),
        .bit_count     (bit_count)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // One frame of len clocks. The pulse is driven on clock 0 for pw clocks
    // when present. Lock state is checked after the edge P+2 (drive index 3).
    task automatic send_frame(input bit present, input bit high, input int len,
                              input int pw, input bit exp_valid, input string req);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            if (i == 3) begin
                check(req, "format_valid", int'(format_valid), int'(exp_valid));
                if (exp_valid) check(req, "format_is_gci", int'(format_is_gci), int'(high));
            end
            if (present && pw == 1 && i >= 3) begin
                // outputs now reflect the edge m = i-1 after the pulse edge
                check("R7", "bit_count", int'(bit_count), ((i - 1) / 2) % 8);
                check("R7", "channel_count", int'(channel_count), (i - 1) / 16);
                check("R8", "bit_boundary", int'(bit_boundary), ((i - 1) % 2 == 0) ? 1 : 0);
                check("R8", "sample_enable", int'(sample_enable), ((i - 1) % 2 == 1) ? 1 : 0);
            end
            if (exp_valid && i > 3) check("R9", "format_is_gci steady", int'(format_is_gci), int'(high));
            frame_pulse = (present && i < pw) ? high : ~high;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1;
        frame_pulse = 1'b1;
        repeat (4) @(negedge clk);
        // R1 reset state
        check("R1", "format_valid", int'(format_valid), 0);
        check("R1", "format_is_gci", int'(format_is_gci), 0);
        check("R1", "channel_count", int'(channel_count), 0);
        check("R1", "bit_count", int'(bit_count), 0);
        check("R1", "bit_boundary", int'(bit_boundary), 1);
        check("R1", "sample_enable", int'(sample_enable), 0);
        rst = 1'b0;

        // Low pulses: first frame candidate, then lock (R2, R3)
        send_frame(1'b1, 1'b0, 512, 1, 1'b0, "R3");
        send_frame(1'b1, 1'b0, 512, 1, 1'b1, "R3");
        send_frame(1'b1, 1'b0, 512, 1, 1'b1, "R2");
        // Missing pulse (R4), then relock
        send_frame(1'b0, 1'b0, 512, 1, 1'b0, "R4");
        send_frame(1'b1, 1'b0, 512, 1, 1'b0, "R4");
        send_frame(1'b1, 1'b0, 512, 1, 1'b1, "R4");
        // Displaced pulse (R5)
        send_frame(1'b1, 1'b0, 300, 1, 1'b1, "R5");
        send_frame(1'b1, 1'b0, 512, 1, 1'b0, "R5");
        send_frame(1'b1, 1'b0, 512, 1, 1'b1, "R5");
        // Two-clock-wide pulses are ignored (R2)
        send_frame(1'b1, 1'b0, 512, 2, 1'b0, "R2");
        send_frame(1'b1, 1'b0, 512, 2, 1'b0, "R2");
        send_frame(1'b1, 1'b0, 512, 2, 1'b0, "R2");
        // Switch to high pulses on a low idle line (R6)
        send_frame(1'b1, 1'b1, 512, 1, 1'b0, "R6");
        send_frame(1'b1, 1'b1, 512, 1, 1'b0, "R6");
        send_frame(1'b1, 1'b1, 512, 1, 1'b1, "R6");
        send_frame(1'b1, 1'b1, 512, 1, 1'b1, "R6");

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule